// File: doc/BRIEF.md
# Saturating Vector Narrowing Pack Unit

This block takes two 256-bit source vectors, each carrying eight signed 32-bit elements, and narrows every element to 16 bits. The sixteen results form one 256-bit output vector. Narrowing can clamp to the signed 16-bit range or to the unsigned 16-bit range. It can also keep only the low 16 bits without clamping.

By default the result follows 128-bit lane order. Each lane holds four narrowed elements of the first operand followed by four narrowed elements of the second operand, so the two sources come out interleaved in blocks of four. With the order select raised, the unit also swaps the two middle 64-bit quadwords of the packed result. The output then holds all eight elements of the first operand followed by all eight elements of the second.

Operands enter through a valid/ready handshake. The result is held in a single output register that has its own valid/ready pair. Both the narrowing mode and the order select are captured together with the operands.

Top module: `vpack_unit`

## Requirements
- R1: While `rst_n` is low and in the first cycle after reset, `out_valid` is 0 and `in_ready` is 1.
- R2: With `in_seq`=0, output 16-bit word w (bits 16w+15:16w) is taken as follows. Words 0-3 come from A elements 0-3, words 4-7 from B elements 0-3, words 8-11 from A elements 4-7, and words 12-15 from B elements 4-7. Element i of a source occupies bits 32i+31:32i. For example, A={0,1,0,1,1,1,0,1} and B={1,1,1,1,0,0,0,1} give {0,1,0,1,1,1,1,1,1,1,0,1,0,0,0,1}.
- R3: With `in_seq`=1, output words 0-7 are A elements 0-7 and words 8-15 are B elements 0-7. This is the lane order with its 64-bit quadwords taken in the order 0,2,1,3.
- R4: `in_sat`=2'b00 or 2'b11 selects signed clamping. Inputs above 32767 give 16'h7FFF, inputs below -32768 give 16'h8000, and all other inputs pass unchanged as 16-bit values.
- R5: `in_sat`=2'b01 selects unsigned clamping. Negative inputs give 16'h0000, inputs above 65535 give 16'hFFFF, and inputs from 0 to 65535 give their low 16 bits.
- R6: `in_sat`=2'b10 keeps the low 16 bits of each input without clamping.
- R7: An input is accepted on a rising edge where `in_valid` and `in_ready` are both 1. On the following edge `out_valid` is 1 and `out_data` holds that input's result.
- R8: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0, and `out_valid` and `out_data` stay unchanged on the next edge.
- R9: Operand, mode and order values presented while `in_ready` is 0 have no effect on the held result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operands and controls are valid |
| in_ready | output | 1 | Unit can accept operands this cycle |
| in_a | input | 256 | First source, eight signed 32-bit elements |
| in_b | input | 256 | Second source, eight signed 32-bit elements |
| in_sat | input | 2 | Narrowing mode: 00/11 signed, 01 unsigned, 10 truncate |
| in_seq | input | 1 | 0 lane order, 1 sequential order |
| out_valid | output | 1 | Result register holds a valid result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 256 | Sixteen 16-bit narrowed elements |

## Verification
Every result is due exactly one rising edge after the edge that accepts its operands, because only the output register lies on the path. The bench drives inputs on falling edges and samples `out_valid` and `out_data` on the falling edge that follows the accepting rising edge. During a stall, the held result is sampled again one and two falling edges later, and the release is checked one edge after `out_ready` rises.

// File: rtl/vpack_pkg.sv
// Shared types for the vector narrowing pack unit.
// Assumes a 2-bit narrowing mode field; code 11 aliases signed clamping.
package vpack_pkg;
    typedef enum logic [1:0] {
        SAT_SIGNED     = 2'b00,
        SAT_UNSIGNED   = 2'b01,
        SAT_TRUNC      = 2'b10,
        SAT_SIGNED_ALT = 2'b11
    } sat_mode_e;
endpackage

// File: rtl/vpack_narrow.sv
// Narrows one signed IW-bit element to OW bits by signed clamping,
// unsigned clamping or truncation. Purely combinational.
// Assumes IW > OW + 1.
module vpack_narrow
    import vpack_pkg::*;
#(
    parameter int IW = 32,
    parameter int OW = 16
) (
    input  logic [IW-1:0] elem_i,
    input  sat_mode_e     mode_i,
    output logic [OW-1:0] elem_o
);
    localparam logic [OW-1:0] S_MAX = {1'b0, {(OW-1){1'b1}}};
    localparam logic [OW-1:0] S_MIN = {1'b1, {(OW-1){1'b0}}};
    localparam logic [OW-1:0] U_MAX = {OW{1'b1}};

    logic neg;
    logic s_over_pos;
    logic s_over_neg;
    logic u_over;

    // Range detection from the bits above the output width
    always_comb begin
        neg        = elem_i[IW-1];
        s_over_pos = !neg && (|elem_i[IW-2:OW-1]);
        s_over_neg = neg && !(&elem_i[IW-2:OW-1]);
        u_over     = !neg && (|elem_i[IW-2:OW]);
    end

    // Result selection by narrowing mode
    always_comb begin
        unique case (mode_i)
            SAT_UNSIGNED: begin
                if (neg)         elem_o = '0;
                else if (u_over) elem_o = U_MAX;
                else             elem_o = elem_i[OW-1:0];
            end
            SAT_TRUNC: elem_o = elem_i[OW-1:0];
            default: begin
                if (s_over_pos)      elem_o = S_MAX;
                else if (s_over_neg) elem_o = S_MIN;
                else                 elem_o = elem_i[OW-1:0];
            end
        endcase
    end
endmodule

// File: rtl/vpack_lane_pack.sv
// Narrows both operands and places the results in lane order: each
// LANE_W-bit output lane holds that lane's A elements, then its B elements.
// Assumes IW = 2*OW so each input lane fills half an output lane.
module vpack_lane_pack
    import vpack_pkg::*;
#(
    parameter int VEC_W  = 256,
    parameter int LANE_W = 128,
    parameter int IW     = 32,
    parameter int OW     = 16
) (
    input  logic [VEC_W-1:0] a_i,
    input  logic [VEC_W-1:0] b_i,
    input  sat_mode_e        mode_i,
    output logic [VEC_W-1:0] packed_o
);
    localparam int N_OUT       = VEC_W / OW;
    localparam int OUT_PER_LN  = LANE_W / OW;
    localparam int HALF_LN     = OUT_PER_LN / 2;
    localparam int IN_PER_LN   = LANE_W / IW;

    for (genvar w = 0; w < N_OUT; w++) begin : g_word
        localparam int LN  = w / OUT_PER_LN;
        localparam int K   = w % OUT_PER_LN;
        localparam int SRC = LN * IN_PER_LN + (K % HALF_LN);
        logic [IW-1:0] src_elem;
        if (K < HALF_LN) begin : g_from_a
            assign src_elem = a_i[SRC*IW +: IW];
        end else begin : g_from_b
            assign src_elem = b_i[SRC*IW +: IW];
        end
        vpack_narrow #(.IW(IW), .OW(OW)) u_narrow (
            .elem_i (src_elem),
            .mode_i (mode_i),
            .elem_o (packed_o[w*OW +: OW])
        );
    end
endmodule

// File: rtl/vpack_qperm.sv
// Optional cross-lane permute of half-lane chunks. When seq_i is set, the
// first half of the output takes the A halves and the second half takes the
// B halves, which restores source order. Combinational.
module vpack_qperm #(
    parameter int VEC_W  = 256,
    parameter int LANE_W = 128
) (
    input  logic [VEC_W-1:0] data_i,
    input  logic             seq_i,
    output logic [VEC_W-1:0] data_o
);
    localparam int CHUNK_W = LANE_W / 2;
    localparam int N_CHUNK = VEC_W / CHUNK_W;
    localparam int HALF_N  = N_CHUNK / 2;

    logic [VEC_W-1:0] perm;

    for (genvar j = 0; j < N_CHUNK; j++) begin : g_chunk
        localparam int SRC = (j < HALF_N) ? 2 * j : 2 * (j - HALF_N) + 1;
        assign perm[j*CHUNK_W +: CHUNK_W] = data_i[SRC*CHUNK_W +: CHUNK_W];
    end

    // Order selection
    always_comb data_o = seq_i ? perm : data_i;
endmodule

// File: rtl/vpack_unit.sv
// Top of the vector narrowing pack unit: lane pack, optional permute, and
// a single output register with valid/ready on both sides.
// Assumes a synchronous active-low reset.
module vpack_unit
    import vpack_pkg::*;
#(
    parameter int VEC_W  = 256,
    parameter int LANE_W = 128,
    parameter int IW     = 32,
    parameter int OW     = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [VEC_W-1:0] in_a,
    input  logic [VEC_W-1:0] in_b,
    input  logic [1:0]       in_sat,
    input  logic             in_seq,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [VEC_W-1:0] out_data
);
    logic [VEC_W-1:0] lane_res;
    logic [VEC_W-1:0] final_res;
    logic             accept;

    vpack_lane_pack #(.VEC_W(VEC_W), .LANE_W(LANE_W), .IW(IW), .OW(OW)) u_lane (
        .a_i      (in_a),
        .b_i      (in_b),
        .mode_i   (sat_mode_e'(in_sat)),
        .packed_o (lane_res)
    );

    vpack_qperm #(.VEC_W(VEC_W), .LANE_W(LANE_W)) u_perm (
        .data_i (lane_res),
        .seq_i  (in_seq),
        .data_o (final_res)
    );

    // Ready when the output register is empty or being drained
    always_comb begin
        in_ready = !out_valid || out_ready;
        accept   = in_valid && in_ready;
    end

    // Output valid flag
    always_ff @(posedge clk) begin
        if (!rst_n)          out_valid <= 1'b0;
        else if (accept)     out_valid <= 1'b1;
        else if (out_ready)  out_valid <= 1'b0;
    end

    // Output data register, loaded only on accept
    always_ff @(posedge clk) begin
        if (!rst_n)      out_data <= '0;
        else if (accept) out_data <= final_res;
    end
endmodule

// File: rtl/vpack_unit_chk.sv
// Property checker for vpack_unit, attached by bind.
module vpack_unit_chk #(
    parameter int VEC_W = 256
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic [VEC_W-1:0] in_a,
    input logic [1:0]       in_sat,
    input logic             out_valid,
    input logic             out_ready,
    input logic [VEC_W-1:0] out_data
);
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && in_ready));

    assert_accept_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    assert_stall_not_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    assert_signed_clamp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_sat == 2'b00 && !in_a[31] && (|in_a[30:15]))
        |=> (out_data[15:0] == 16'h7FFF));

    assert_unsigned_neg_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_sat == 2'b01 && in_a[31])
        |=> (out_data[15:0] == 16'h0000));
endmodule

bind vpack_unit vpack_unit_chk #(.VEC_W(VEC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_a      (in_a),
    .in_sat    (in_sat),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
);

// File: tb/tb_vpack_unit.sv
module tb_vpack_unit;
    typedef logic [7:0][31:0] vec8_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [255:0] in_a = '0;
    logic [255:0] in_b = '0;
    logic [1:0]   in_sat = 2'b00;
    logic         in_seq = 1'b0;
    logic         out_valid;
    logic         out_ready = 1'b1;
    logic [255:0] out_data;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    vpack_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_a(in_a), .in_b(in_b), .in_sat(in_sat), .in_seq(in_seq),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    // Patterns list element 7 first, element 0 last
    localparam vec8_t BND_A = '{32'h7FFFFFFF, 32'hFFFFFFFF, 32'h00010000, 32'h0000FFFF,
                                32'hFFFF7FFF, 32'hFFFF8000, 32'h00008000, 32'h00007FFF};
    localparam vec8_t BND_B = '{32'h00000000, 32'hFFFF8001, 32'h00003039, 32'hFFFE7960,
                                32'h000186A0, 32'hFFFFFFFE, 32'h00000001, 32'h80000000};
    localparam vec8_t EX_A  = '{32'd1, 32'd0, 32'd1, 32'd1, 32'd1, 32'd0, 32'd1, 32'd0};
    localparam vec8_t EX_B  = '{32'd1, 32'd0, 32'd0, 32'd0, 32'd1, 32'd1, 32'd1, 32'd1};
    localparam vec8_t CNT_A = '{32'd7, 32'd6, 32'd5, 32'd4, 32'd3, 32'd2, 32'd1, 32'd0};
    localparam vec8_t CNT_B = '{32'd15, 32'd14, 32'd13, 32'd12, 32'd11, 32'd10, 32'd9, 32'd8};

    localparam int NV = 8;
    localparam vec8_t    TBL_A   [NV] = '{EX_A, BND_A, BND_A, BND_A, BND_A, BND_A, CNT_A, BND_A};
    localparam vec8_t    TBL_B   [NV] = '{EX_B, BND_B, BND_B, BND_B, BND_B, BND_B, CNT_B, BND_B};
    localparam logic [1:0] TBL_SAT[NV] = '{2'b00, 2'b00, 2'b01, 2'b10, 2'b00, 2'b11, 2'b01, 2'b01};
    localparam logic     TBL_SEQ [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1};

    // Reference narrowing using integer arithmetic
    function automatic logic [15:0] ref_narrow(logic [31:0] x, logic [1:0] m);
        longint v = longint'($signed(x));
        if (m == 2'b10) return x[15:0];
        if (m == 2'b01) begin
            if (v < 0) return 16'h0000;
            if (v > 65535) return 16'hFFFF;
            return x[15:0];
        end
        if (v > 32767) return 16'h7FFF;
        if (v < -32768) return 16'h8000;
        return x[15:0];
    endfunction

    // Reference result: sequential order first, lane order swaps words 4-7 with 8-11
    function automatic logic [255:0] ref_pack(vec8_t a, vec8_t b, logic [1:0] m, logic seq);
        logic [15:0] s [16];
        logic [255:0] r;
        for (int j = 0; j < 8; j++) begin
            s[j]     = ref_narrow(a[j], m);
            s[j + 8] = ref_narrow(b[j], m);
        end
        for (int w = 0; w < 16; w++) begin
            int src = w;
            if (!seq && w >= 4 && w < 8)   src = w + 4;
            if (!seq && w >= 8 && w < 12)  src = w - 4;
            r[w*16 +: 16] = s[src];
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [255:0] act,
                         input logic [255:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Drive one accepted input and check the result one edge later
    task automatic send_check(vec8_t a, vec8_t b, logic [1:0] m, logic seq, string req);
        logic [255:0] exp;
        exp = ref_pack(a, b, m, seq);
        @(negedge clk);
        in_valid = 1'b1; in_a = a; in_b = b; in_sat = m; in_seq = seq; out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid === 1'b1, {req, " R7 valid"}, {255'd0, out_valid}, 256'd1);
        check(out_data === exp, req, out_data, exp);
    endtask

    initial begin
        #1_000_000;
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [255:0] exp1;
        logic [255:0] ex_exp;
        repeat (2) @(negedge clk);
        check(out_valid === 1'b0 && in_ready === 1'b1, "R1 in reset",
              {254'd0, out_valid, in_ready}, 256'd1);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid === 1'b0 && in_ready === 1'b1, "R1 after reset",
              {254'd0, out_valid, in_ready}, 256'd1);

        // Example from R2 with explicit expected words
        ex_exp = '0;
        begin
            int wv [16] = '{0,1,0,1,1,1,1,1,1,1,0,1,0,0,0,1};
            for (int w = 0; w < 16; w++) ex_exp[w*16 +: 16] = 16'(wv[w]);
        end
        send_check(EX_A, EX_B, 2'b00, 1'b0, "R2 example");
        check(out_data === ex_exp, "R2 explicit", out_data, ex_exp);

        // Table walk: R4 signed, R5 unsigned, R6 truncate, R3 sequential
        for (int i = 0; i < NV; i++) begin
            string tag;
            case (TBL_SAT[i])
                2'b01:   tag = "R5";
                2'b10:   tag = "R6";
                default: tag = "R4";
            endcase
            send_check(TBL_A[i], TBL_B[i], TBL_SAT[i], TBL_SEQ[i],
                       $sformatf("%s %s vec%0d", tag, TBL_SEQ[i] ? "R3" : "R2", i));
        end

        // Stall: R8 hold and R9 ignore inputs while not ready
        exp1 = ref_pack(BND_A, BND_B, 2'b01, 1'b1);
        @(negedge clk);
        in_valid = 1'b1; in_a = BND_A; in_b = BND_B; in_sat = 2'b01; in_seq = 1'b1;
        out_ready = 1'b0;
        @(negedge clk);
        in_a = CNT_A; in_b = CNT_B; in_sat = 2'b00; in_seq = 1'b0;
        check(out_data === exp1, "R7 stalled load", out_data, exp1);
        check(in_ready === 1'b0, "R8 not ready", {255'd0, in_ready}, 256'd0);
        @(negedge clk);
        check(out_valid === 1'b1, "R8 valid held", {255'd0, out_valid}, 256'd1);
        check(out_data === exp1, "R9 data held", out_data, exp1);
        in_valid = 1'b0; out_ready = 1'b1;
        @(negedge clk);
        check(out_valid === 1'b0, "R8 release", {255'd0, out_valid}, 256'd0);

        finish_run();
    end
endmodule